// File: doc/BRIEF.md
# Selectable PRBS Pattern Generator and Loopback Checker

This block gives each channel of a multi-lane link a built-in bit-error test. Each channel's generator emits one pseudo-random bit per clock on its transmit lane. The channel's checker watches the bit that returns on its receive lane. One static select input picks a short (period 127) or long (period 8,388,607) maximal-length sequence for every channel at once. The generator and the checker of each channel have their own enables, so either can run without the other.

The checker needs no alignment step. It shifts the received bits into a history register and predicts each new bit from that history, so it locks onto the incoming stream on its own. Each mismatch drives a registered per-channel error flag and adds one to a saturating 16-bit error count. The host reads a count with a one-cycle read strobe and a channel index. The read returns the count, and the count is cleared after the read. A test therefore starts with one read whose value is thrown away. After that, a read of zero means the lane ran clean since the previous read. A synchronous datapath clear puts all generators, checkers and counts back to their start state.

Top module: `prbs_lane_tester`

## Requirements
- R1: With `short_seq` high, each transmit bit is the feedback of x^7+x^6+1: new = h[6]^h[5], where h is the generator history and h[0] is the newest bit. With `short_seq` low, new = h[22]^h[17] (x^23+x^18+1). The history starts at all ones, and the new bit is shifted in at h[0]. The first bit appears on `tx_bit` one clock after the enable is first sampled high.
- R2: While a channel's generator enable is low, its `tx_bit` is 0 and its history is held. When the enable returns high, the sequence resumes at the next bit.
- R3: After at least 23 error-free received bits, the checker reports no mismatch on a clean looped-back stream, whatever the phase.
- R4: One inverted received bit is counted as exactly three errors: the bit itself, and the two later bits whose prediction uses it as a tap.
- R5: While a channel's checker enable is low, no error is counted and its `err_flag` stays low. Its history keeps loading.
- R6: The error count saturates at 16'hFFFF and does not wrap.
- R7: A read (`rd_stb` high with channel `rd_ch`) returns the current count on `rd_cnt` in the same cycle. The count is 0 after the next clock edge.
- R8: If a read and a mismatch on the same channel fall in one clock, the count becomes 1 rather than 0.
- R9: `err_flag` is high in the clock after each mismatch, and low in the clock after a matching bit.
- R10: A `dp_clr` clock sets the generator and checker histories to all ones, drives `tx_bit` to 0 and clears the counts.
- R11: Errors on one channel leave the other channels' counts and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_seq | input | 1 | 1: period-127 sequence, 0: period-8,388,607 sequence |
| dp_clr | input | 1 | Synchronous datapath clear |
| gen_en | input | NUM_CH | Generator enable per channel |
| chk_en | input | NUM_CH | Checker enable per channel |
| rx_bit | input | NUM_CH | Received bit per channel |
| tx_bit | output | NUM_CH | Transmitted bit per channel |
| err_flag | output | NUM_CH | Registered live error flag per channel |
| rd_stb | input | 1 | Count read strobe |
| rd_ch | input | SEL_W | Channel index of the read |
| rd_cnt | output | CNT_W | Count of the selected channel |

## Verification
A host read and a detected bit error can land on the same counter in the same clock. The bench provokes this by asserting the read strobe and inverting one looped-back bit on the same falling edge. It then expects the read to return the old count of zero. Because of the two tap echoes that follow, a later read must then return three rather than two.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int HIST_W   = 23;
  localparam int SHORT_TA = 7;
  localparam int SHORT_TB = 6;
  localparam int LONG_TA  = 23;
  localparam int LONG_TB  = 18;

  typedef logic [HIST_W-1:0] hist_t;

  // Predicted next bit from a history whose bit 0 is the newest.
  function automatic logic prbs_next(hist_t h, logic short_sel);
    logic fb;
    if (short_sel) fb = h[SHORT_TA-1] ^ h[SHORT_TB-1];
    else           fb = h[LONG_TA-1] ^ h[LONG_TB-1];
    return fb;
  endfunction
endpackage

// File: rtl/prbs_rst_sync.sv
module prbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/prbs_lfsr_gen.sv
module prbs_lfsr_gen
  import prbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic short_sel,
  output logic tx_bit
);
  hist_t state_q, state_d;
  logic  tx_q, tx_d;
  logic  state_ce;
  logic  fb;

  assign fb       = prbs_next(state_q, short_sel);
  assign state_ce = clr | en;

  always_comb begin
    state_d = state_q;
    tx_d    = 1'b0;
    if (clr) begin
      state_d = '1;
    end else if (en) begin
      state_d = {state_q[HIST_W-2:0], fb};
      tx_d    = fb;
      if (state_d == '0) state_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
      tx_q    <= 1'b0;
    end else begin
      if (state_ce) state_q <= state_d;
      tx_q <= tx_d;
    end
  end

  assign tx_bit = tx_q;

  a_r2_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tx_bit);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(state_q));
  a_r1_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/prbs_sync_chk.sv
module prbs_sync_chk
  import prbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic short_sel,
  input  logic rx_bit,
  output logic miss,
  output logic err_flag
);
  hist_t hist_q, hist_d;
  logic  pred;
  logic  flag_q, flag_d;

  assign pred = prbs_next(hist_q, short_sel);
  assign miss = en & ~clr & (rx_bit ^ pred);

  always_comb begin
    if (clr) hist_d = '1;
    else     hist_d = {hist_q[HIST_W-2:0], rx_bit};
    flag_d = miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      flag_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      flag_q <= flag_d;
    end
  end

  assign err_flag = flag_q;

  a_r9_flag_on: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> err_flag);
  a_r5_flag_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !err_flag);
  a_r10_clr_hist: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> hist_q == '1);
endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             rd,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign cnt_ce = clr | rd | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (rd)                    cnt_d = inc ? CNT_ONE : '0;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !rd && !clr) |=> cnt == CNT_MAX);
  a_r7_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !inc) |=> cnt == '0);
  a_r8_rd_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && inc && !clr) |=> cnt == CNT_ONE);
  a_r10_clr_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/prbs_lane_tester.sv
module prbs_lane_tester #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              short_seq,
  input  logic              dp_clr,
  input  logic [NUM_CH-1:0] gen_en,
  input  logic [NUM_CH-1:0] chk_en,
  input  logic [NUM_CH-1:0] rx_bit,
  output logic [NUM_CH-1:0] tx_bit,
  output logic [NUM_CH-1:0] err_flag,
  input  logic              rd_stb,
  input  logic [SEL_W-1:0]  rd_ch,
  output logic [CNT_W-1:0]  rd_cnt
);
  logic              rst_n_s;
  logic [NUM_CH-1:0] miss;
  logic [NUM_CH-1:0] rd_hit;
  logic [CNT_W-1:0]  cnt_w [NUM_CH];

  prbs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rd_hit[c] = rd_stb && (rd_ch == SEL_W'(c));

    prbs_lfsr_gen u_gen (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .clr       (dp_clr),
      .en        (gen_en[c]),
      .short_sel (short_seq),
      .tx_bit    (tx_bit[c])
    );

    prbs_sync_chk u_chk (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .clr       (dp_clr),
      .en        (chk_en[c]),
      .short_sel (short_seq),
      .rx_bit    (rx_bit[c]),
      .miss      (miss[c]),
      .err_flag  (err_flag[c])
    );

    prbs_err_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr   (dp_clr),
      .inc   (miss[c]),
      .rd    (rd_hit[c]),
      .cnt   (cnt_w[c])
    );
  end

  always_comb begin
    rd_cnt = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch == SEL_W'(c)) rd_cnt = cnt_w[c];
    end
  end

  a_r7_one_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(rd_hit));
endmodule

// File: tb/sim_prbs_lane_tester.sv
module sim_prbs_lane_tester;
  localparam int NCH = 2;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           short_seq, dp_clr, rd_stb;
  logic [NCH-1:0] gen_en, chk_en, inj, tx_bit, err_flag, rx_bit;
  logic [0:0]     rd_ch;
  logic [CW-1:0]  rd_cnt;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  exp_q[$];
  logic [22:0] model;

  always #10 clk = ~clk;

  assign rx_bit = tx_bit ^ inj;

  prbs_lane_tester #(.NUM_CH(NCH), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .short_seq(short_seq), .dp_clr(dp_clr),
    .gen_en(gen_en), .chk_en(chk_en), .rx_bit(rx_bit), .tx_bit(tx_bit),
    .err_flag(err_flag), .rd_stb(rd_stb), .rd_ch(rd_ch), .rd_cnt(rd_cnt)
  );

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit model_step(bit short_sel);
    bit fb;
    fb = short_sel ? (model[6] ^ model[5]) : (model[22] ^ model[17]);
    model = {model[21:0], fb};
    return fb;
  endfunction

  // Driver: one clock per item, expected transmit bit pushed to the scoreboard.
  task automatic run_gen(bit en, int n);
    for (int i = 0; i < n; i++) begin
      gen_en = {NCH{en}};
      if (en) exp_q.push_back(model_step(short_seq));
      else    exp_q.push_back(1'b0);
      @(negedge clk);
    end
  endtask

  // Monitor: compares both lanes shortly after each rising edge.
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      check("R1/R2 tx lane0", int'(tx_bit[0]), int'(e));
      check("R1/R2 tx lane1", int'(tx_bit[1]), int'(e));
    end
  end

  task automatic do_read(int ch, int expv, string tag);
    rd_ch  = ch[0:0];
    rd_stb = 1'b1;
    #1;
    if (expv >= 0) check(tag, int'(rd_cnt), expv);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic flip(int ch);
    inj[ch] = 1'b1;
    @(negedge clk);
    inj[ch] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; short_seq = 1'b1; dp_clr = 1'b0; rd_stb = 1'b0; rd_ch = '0;
    gen_en = '0; chk_en = '0; inj = '0;
    model = '1;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // Reset state
    check("R10 reset tx", int'(tx_bit), 0);
    check("R10 reset flag", int'(err_flag), 0);
    check("R10 reset count", int'(rd_cnt), 0);

    // R1: short sequence from the all-ones seed
    chk_en = '1;
    run_gen(1'b1, 40);
    // R2: pause then resume
    run_gen(1'b0, 5);
    run_gen(1'b1, 30);
    idle(30);
    // R7: discard read, then R3 clean run reads zero
    do_read(0, -1, "R7 discard");
    do_read(1, -1, "R7 discard");
    idle(40);
    do_read(0, 0, "R3 clean lane0");
    do_read(1, 0, "R3 clean lane1");

    // R4/R9/R11: single flip on lane0
    inj[0] = 1'b1;
    @(negedge clk);
    inj[0] = 1'b0;
    check("R9 flag after miss", int'(err_flag[0]), 1);
    check("R11 other flag", int'(err_flag[1]), 0);
    @(negedge clk);
    check("R9 flag after match", int'(err_flag[0]), 0);
    idle(12);
    do_read(0, 3, "R4 three errors prbs7");
    do_read(0, 0, "R7 cleared after read");
    do_read(1, 0, "R11 lane1 untouched");

    // R5: checker disabled
    chk_en[0] = 1'b0;
    inj[0] = 1'b1;
    @(negedge clk);
    inj[0] = 1'b0;
    check("R5 flag low when disabled", int'(err_flag[0]), 0);
    idle(12);
    chk_en[0] = 1'b1;
    idle(3);
    do_read(0, 0, "R5 nothing counted");

    // R8: read and mismatch in the same clock
    inj[0] = 1'b1;
    rd_ch = 1'b0;
    rd_stb = 1'b1;
    #1;
    check("R8 read returns old count", int'(rd_cnt), 0);
    @(negedge clk);
    inj[0] = 1'b0;
    rd_stb = 1'b0;
    check("R8 count kept at one", int'(rd_cnt), 1);
    idle(12);
    do_read(0, 3, "R8 no error lost");

    // R1: long sequence after a datapath clear
    short_seq = 1'b0;
    dp_clr = 1'b1;
    @(negedge clk);
    dp_clr = 1'b0;
    model = '1;
    run_gen(1'b1, 60);
    idle(5);
    do_read(0, -1, "R7 discard");
    idle(5);
    flip(0);
    idle(30);
    do_read(0, 3, "R4 three errors prbs23");

    // R10: clear drops counts and restarts the sequence
    flip(0);
    idle(2);
    dp_clr = 1'b1;
    @(negedge clk);
    dp_clr = 1'b0;
    check("R10 tx low after clear", int'(tx_bit[0]), 0);
    do_read(0, 0, "R10 count cleared");
    idle(40);
    do_read(1, -1, "R7 discard");

    // R6: saturation on lane1
    inj[1] = 1'b1;
    idle(65600);
    check("R9 flag high while errored", int'(err_flag[1]), 1);
    check("R6 lane0 untouched flag", int'(err_flag[0]), 0);
    rd_ch = 1'b1;
    #1;
    check("R6 saturated", int'(rd_cnt), 65535);
    idle(1);
    inj[1] = 1'b0;
    idle(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule